// File: doc/BRIEF.md
# Hex Record Stream Memory Loader

The loader sits behind a character receiver and turns a text stream of hex load records into byte writes on a memory port. It takes one ASCII character per cycle in which `in_valid` is high. A record opens with a colon. Hex-digit pairs follow with no gaps between them: a byte count, a 16-bit start address (high byte first), a record type, the payload bytes and a checksum byte. The loader writes each data-record payload byte as soon as the byte is parsed. Bytes go to consecutive addresses that start at the record's start address.

A 16-bit upper address word supplies bits 31..16 of every write address. Only an extended-address record (type 04) with a good checksum changes this word, and the new value holds until the next such record. The end-of-file record (type 01) raises `done`. Checksum faults and format faults each set their own sticky flag. Only reset clears these flags.

Top module: `hexrec_loader`

## Requirements
- R1: For a record of type 0x00, the loader emits one `wr_en` pulse per payload byte, in stream order. The address is {upper word, start address + byte index}, where the low 16 bits wrap. The pulse comes one cycle after the character that completes the byte.
- R2: A type 0x04 record with count 2 and a valid checksum loads its two payload bytes, first byte high, into the upper address word. With an upper word of 0x0001, a data record at 0x0170 writes from 0x00010170.
- R3: The upper word applies to every later data record until another valid type 0x04 record arrives.
- R4: A record is valid when the 8-bit sum of all its bytes, the checksum included, is 0x00. When this sum is not 0x00, `err_csum` is set and stays set. A type 0x04 record that fails the checksum leaves the upper word unchanged. The payload writes of a data record that fails the checksum have already been made.
- R5: The digits 0-9, A-F and a-f are accepted as hex digits.
- R6: Characters outside a record, carriage return and line feed among them, cause no write and no error.
- R7: A non-hex character inside a record sets `err_format`, which stays set. The rest of that record is discarded until the next colon. A record type other than 0x00, 0x01 or 0x04 also sets `err_format`, and so does a type 0x04 record whose count is not 2 or a type 0x01 record whose count is not 0. A colon inside a record sets `err_format` and starts a new record.
- R8: `done` rises only after a type 0x01 record whose checksum is valid (for example `:00000001FF`), and it stays high until reset.
- R9: Reset clears `done`, `err_csum`, `err_format`, `wr_en` and the upper word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A character is present on `in_char` |
| in_char | input | 8 | ASCII character |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | 32 | Byte write address |
| wr_data | output | 8 | Byte to write |
| done | output | 1 | Valid end-of-file record seen |
| err_csum | output | 1 | Sticky checksum fault |
| err_format | output | 1 | Sticky format fault |

## Verification
On every cycle the assertions check four things. A write only follows an accepted character. `done` and both error flags never drop once set, outside reset. `wr_en` never rises while reset is held.

Only the scenarios can show the rest: the exact address and data sequence of each record, that the upper word persists across records or is rejected after a bad checksum, recovery after a malformed record, and that reset returns the upper word to zero. A scoreboard queue holds the expected writes and compares them against the strobes the loader produces.

// File: rtl/hexrec_loader.sv
module hexrec_loader (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_char,
  output logic        wr_en,
  output logic [31:0] wr_addr,
  output logic [7:0]  wr_data,
  output logic        done,
  output logic        err_csum,
  output logic        err_format
);
  localparam logic [2:0] S_IDLE = 3'd0, S_CNT = 3'd1, S_AH = 3'd2, S_AL = 3'd3,
                         S_TYP = 3'd4, S_DAT = 3'd5, S_CHK = 3'd6;

  logic [2:0]  st;
  logic        hi_half;
  logic [3:0]  hi_nib;
  logic [7:0]  cnt, remaining, rtype, sum;
  logic [15:0] addr16, upper, ext;
  logic        is_hex;
  logic [3:0]  nib;
  logic [7:0]  b;
  logic        type_bad;

  always_comb begin
    is_hex = 1'b1;
    nib    = 4'd0;
    if (in_char >= "0" && in_char <= "9")      nib = 4'(in_char - "0");
    else if (in_char >= "A" && in_char <= "F") nib = 4'(in_char - "A" + 8'd10);
    else if (in_char >= "a" && in_char <= "f") nib = 4'(in_char - "a" + 8'd10);
    else                                       is_hex = 1'b0;
  end

  assign b = {hi_nib, nib};
  assign type_bad = !(b == 8'h00 || (b == 8'h01 && cnt == 8'd0) ||
                      (b == 8'h04 && cnt == 8'd2));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; hi_half <= 1'b0; hi_nib <= 4'd0;
      cnt <= 8'd0; remaining <= 8'd0; rtype <= 8'd0; sum <= 8'd0;
      addr16 <= 16'd0; upper <= 16'd0; ext <= 16'd0;
      wr_en <= 1'b0; wr_addr <= 32'd0; wr_data <= 8'd0;
      done <= 1'b0; err_csum <= 1'b0; err_format <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (in_valid) begin
        if (in_char == ":") begin
          if (st != S_IDLE) err_format <= 1'b1;
          st <= S_CNT; hi_half <= 1'b0; sum <= 8'd0;
        end else if (st == S_IDLE) begin
          hi_half <= 1'b0;
        end else if (!is_hex) begin
          err_format <= 1'b1;
          st <= S_IDLE;
        end else if (!hi_half) begin
          hi_nib  <= nib;
          hi_half <= 1'b1;
        end else begin
          hi_half <= 1'b0;
          sum     <= sum + b;
          case (st)
            S_CNT: begin cnt <= b; remaining <= b; st <= S_AH; end
            S_AH:  begin addr16[15:8] <= b; st <= S_AL; end
            S_AL:  begin addr16[7:0] <= b; st <= S_TYP; end
            S_TYP: begin
              rtype <= b;
              if (type_bad) begin
                err_format <= 1'b1;
                st <= S_IDLE;
              end else begin
                st <= (cnt == 8'd0) ? S_CHK : S_DAT;
              end
            end
            S_DAT: begin
              if (rtype == 8'h00) begin
                wr_en   <= 1'b1;
                wr_addr <= {upper, addr16};
                wr_data <= b;
                addr16  <= addr16 + 16'd1;
              end else begin
                ext <= {ext[7:0], b};
              end
              remaining <= remaining - 8'd1;
              if (remaining == 8'd1) st <= S_CHK;
            end
            S_CHK: begin
              st <= S_IDLE;
              if (8'(sum + b) == 8'd0) begin
                if (rtype == 8'h01) done  <= 1'b1;
                if (rtype == 8'h04) upper <= ext;
              end else begin
                err_csum <= 1'b1;
              end
            end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end
endmodule

module hexrec_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [7:0]  in_char,
  input logic        wr_en,
  input logic [31:0] wr_addr,
  input logic [7:0]  wr_data,
  input logic        done,
  input logic        err_csum,
  input logic        err_format
);
  a_r1_write_follows_char: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(in_valid));
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  a_r4_csum_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_csum |=> err_csum);
  a_r7_format_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_format |=> err_format);
  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !wr_en);
endmodule

bind hexrec_loader hexrec_loader_chk u_chk (.*);

// File: tb/hexrec_loader_test.sv
module hexrec_loader_test;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [7:0] in_char = 8'd0;
  logic wr_en, done, err_csum, err_format;
  logic [31:0] wr_addr;
  logic [7:0] wr_data;

  int errors = 0, checks = 0;
  logic [39:0] expq[$];
  logic [15:0] up_model = 16'd0;
  logic [7:0] pl [8];

  always #5 clk = ~clk;

  hexrec_loader uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_char(in_char),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done),
    .err_csum(err_csum), .err_format(err_format));

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (expq.size() == 0) check("R1 unexpected write", {wr_addr, wr_data}, 40'h0);
      else check("R1 write", {wr_addr, wr_data}, expq.pop_front());
    end
  end

  function automatic logic [7:0] hx(input logic [3:0] v, input bit lc);
    if (v < 4'd10) return 8'("0") + 8'(v);
    return (lc ? 8'("a") : 8'("A")) + 8'(v) - 8'd10;
  endfunction

  task automatic send_char(input logic [7:0] c);
    @(negedge clk);
    in_valid = 1'b1;
    in_char  = c;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] v, input bit lc);
    send_char(hx(v[7:4], lc));
    send_char(hx(v[3:0], lc));
  endtask

  task automatic send_rec(input logic [7:0] n, input logic [15:0] a, input logic [7:0] t,
                          input bit bad, input bit lc);
    logic [7:0] s;
    s = n + a[15:8] + a[7:0] + t;
    for (int i = 0; i < n; i++) s = s + pl[i];
    s = 8'd0 - s;
    if (bad) s = s ^ 8'h5A;
    if (t == 8'h00)
      for (int i = 0; i < n; i++) expq.push_back({up_model, 16'(a + 16'(i)), pl[i]});
    if (t == 8'h04 && !bad) up_model = {pl[0], pl[1]};
    send_char(":");
    send_byte(n, lc); send_byte(a[15:8], lc); send_byte(a[7:0], lc); send_byte(t, lc);
    for (int i = 0; i < n; i++) send_byte(pl[i], lc);
    send_byte(s, lc);
    send_char(8'h0D); send_char(8'h0A);
    idle(2);
  endtask

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check("R9 reset wr_en", wr_en, 0);
    check("R9 reset flags", {done, err_csum, err_format}, 0);

    pl[0] = 8'h11; pl[1] = 8'h22; pl[2] = 8'h33; pl[3] = 8'h44;
    send_rec(8'd4, 16'h0100, 8'h00, 0, 0);
    check("R1 flags clean", {err_csum, err_format}, 0);

    pl[0] = 8'h00; pl[1] = 8'h01;
    send_rec(8'd2, 16'h0000, 8'h04, 0, 0);
    pl[0] = 8'h70; pl[1] = 8'h71; pl[2] = 8'h72;
    send_rec(8'd3, 16'h0170, 8'h00, 0, 0);
    check("R2 ext flags clean", {err_csum, err_format}, 0);

    pl[0] = 8'hA5; pl[1] = 8'h5A;
    send_rec(8'd2, 16'hFFFF, 8'h00, 0, 0);
    check("R3 persist flags clean", {err_csum, err_format}, 0);

    pl[0] = 8'hAB; pl[1] = 8'hCD; pl[2] = 8'hEF;
    send_rec(8'd3, 16'h0ABC, 8'h00, 0, 1);
    check("R5 lowercase flags clean", {err_csum, err_format}, 0);

    send_char(8'h0D); send_char(8'h0A); send_char(8'h0A); send_char(8'h0D);
    idle(2);
    check("R6 line ends ignored", {wr_en, err_csum, err_format}, 0);

    pl[0] = 8'h00; pl[1] = 8'h05;
    send_rec(8'd2, 16'h0000, 8'h04, 1, 0);
    check("R4 bad csum flag", err_csum, 1);
    pl[0] = 8'h99;
    send_rec(8'd1, 16'h0010, 8'h00, 0, 0);
    check("R4 upper kept, queue drained", expq.size(), 0);

    pl[0] = 8'hDE; pl[1] = 8'hAD;
    send_rec(8'd2, 16'h0300, 8'h00, 1, 0);
    check("R4 data bad csum still written", expq.size(), 0);
    check("R7 no format error yet", err_format, 0);

    send_char(":"); send_byte(8'h02, 0); send_byte(8'h04, 0); send_char("0");
    send_char("G"); send_byte(8'h00, 0); send_byte(8'h00, 0); send_byte(8'h11, 0);
    send_char(8'h0D); send_char(8'h0A); idle(2);
    check("R7 bad char flag", err_format, 1);
    pl[0] = 8'h42;
    send_rec(8'd1, 16'h0400, 8'h00, 0, 0);
    check("R7 recovery write", expq.size(), 0);

    send_rec(8'd0, 16'h0000, 8'h01, 1, 0);
    check("R8 bad eof no done", done, 0);
    send_rec(8'd0, 16'h0000, 8'h01, 0, 0);
    check("R8 eof done", done, 1);

    @(negedge clk); rst_n = 1'b0; in_valid = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    check("R9 flags after reset", {done, err_csum, err_format}, 0);
    up_model = 16'd0;
    pl[0] = 8'h77;
    send_rec(8'd1, 16'h0020, 8'h00, 0, 0);
    check("R9 upper cleared", expq.size(), 0);

    idle(4);
    check("R1 final queue empty", expq.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule